// File: doc/BRIEF.md
# Interleaved Converter Output Combiner

This block merges the results of a bank of time-staggered conversion lanes into a single sample stream that runs at the full sample clock rate. A lane pointer steps through the lanes one per clock and wraps back to lane 0. On each clock the strobe input says whether the lane under the pointer has just taken an input sample. When the pointer comes back to that lane a full rotation later, the lane's finished result is picked up and registered as the downstream sample.

The 10-bit lane result sits in the top bits of a 16-bit output word, and the bits below it are zero. An overrange flag goes with each word and has the same timing. Slots where no sample was taken, or where the lane has not reported done, give an invalid, all-zero output. The lanes are treated as result providers with a fixed latency. Their analog behaviour is not part of this block.

Top module: `lane_combiner`

## Requirements
- R1: While reset is high, and on the first clock after it, `smp_vld`, `smp_ovr` and `smp_out` are all 0. The pointer restarts at lane 0 on the first clock edge with reset low.
- R2: The lane pointer advances by one on every clock and wraps from lane LANES-1 (15) to lane 0. The sample registered at the n-th edge after reset is taken from lane n mod 16.
- R3: Strobe high at edge n makes `smp_vld` high after edge n+16, provided that lane's done bit is high at edge n+16. This gives a fixed 16-clock latency.
- R4: Strobe low at edge n makes `smp_vld` low after edge n+16, with `smp_out` and `smp_ovr` at 0.
- R5: When valid, `smp_out` is the 10-bit lane result in bits 15:6, with bits 5:0 at zero. Both extremes are covered: 0 and 1023.
- R6: `smp_ovr` carries the selected lane's overrange bit with the same latency as the data word. It is only high when `smp_vld` is high.
- R7: A sampled slot whose lane has its done bit low at the due edge gives `smp_vld` low and a zero word.
- R8: `smp_vld` stays low for the first 16 clocks after reset, whatever the inputs are.
- R9: With the strobe held high and every lane done, one valid sample comes out on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | The lane under the pointer takes a sample this clock |
| lane_done | input | 16 | Per-lane result-ready bits, bit k for lane k |
| lane_res | input | 160 | Per-lane 10-bit results, lane k in bits 10k+9:10k |
| lane_ovr | input | 16 | Per-lane overrange bits, bit k for lane k |
| smp_out | output | 16 | Upper-justified sample word |
| smp_vld | output | 1 | Sample word valid |
| smp_ovr | output | 1 | Overrange flag for the current word |

## Verification
A strobe presented at edge n is due at the outputs just after edge n+16. That output is formed from the lane inputs present at edge n+16, and the data, valid and overrange outputs all arrive together. The bench keeps its own edge count from reset and a strobe history. At each falling edge it checks the outputs against the expectation built one edge earlier, so every comparison lands exactly one register stage after the edge that produced it. The sweeps cover a continuous strobe, sparse strobe patterns, lanes with done low, and results at 0 and 1023 across several pointer wraps.

// File: rtl/combiner_pkg.sv
package combiner_pkg;
  localparam int unsigned LANES_DEF = 16;
  localparam int unsigned RES_W_DEF = 10;
  localparam int unsigned OUT_W_DEF = 16;
endpackage

// File: rtl/cmb_lane_ptr.sv
module cmb_lane_ptr #(
  parameter int unsigned LANES = 16,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SEL_W-1:0] ptr
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(LANES - 1);

  always_ff @(posedge clk) begin
    if (rst)              ptr <= '0;
    else if (ptr == LAST) ptr <= '0;
    else                  ptr <= ptr + 1'b1;
  end

  // R2: step by one each clock, wrap at the last lane
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
  a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/cmb_slot_track.sv
module cmb_slot_track #(
  parameter int unsigned LANES = 16,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ptr,
  input  logic             stb,
  output logic             pend_sel
);
  logic [LANES-1:0] pend;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)                     pend[k] <= 1'b0;
        else if (ptr == SEL_W'(k))   pend[k] <= stb;
      end
    end
  endgenerate

  assign pend_sel = pend[ptr];

  // R8: no slot is marked as pending straight out of reset
  a_r8_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend == '0));
endmodule

// File: rtl/cmb_lane_sel.sv
module cmb_lane_sel #(
  parameter int unsigned LANES = 16,
  parameter int unsigned RES_W = 10,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [SEL_W-1:0]       ptr,
  input  logic [LANES-1:0]       done,
  input  logic [LANES*RES_W-1:0] res_bus,
  input  logic [LANES-1:0]       ovr,
  output logic [RES_W-1:0]       sel_res,
  output logic                   sel_done,
  output logic                   sel_ovr
);
  logic [RES_W-1:0] res_arr [LANES];

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_unpack
      assign res_arr[k] = res_bus[k*RES_W +: RES_W];
    end
  endgenerate

  assign sel_res  = res_arr[ptr];
  assign sel_done = done[ptr];
  assign sel_ovr  = ovr[ptr];
endmodule

// File: rtl/lane_combiner.sv
module lane_combiner
  import combiner_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned RES_W = RES_W_DEF,
  parameter int unsigned OUT_W = OUT_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_stb,
  input  logic [LANES-1:0]       lane_done,
  input  logic [LANES*RES_W-1:0] lane_res,
  input  logic [LANES-1:0]       lane_ovr,
  output logic [OUT_W-1:0]       smp_out,
  output logic                   smp_vld,
  output logic                   smp_ovr
);
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned PAD_W = OUT_W - RES_W;

  logic [SEL_W-1:0] ptr;
  logic             pend_sel;
  logic [RES_W-1:0] sel_res;
  logic             sel_done;
  logic             sel_ovr;
  logic             take;

  cmb_lane_ptr #(.LANES(LANES)) u_ptr (
    .clk(clk), .rst(rst), .ptr(ptr)
  );

  cmb_slot_track #(.LANES(LANES)) u_track (
    .clk(clk), .rst(rst), .ptr(ptr), .stb(smp_stb), .pend_sel(pend_sel)
  );

  cmb_lane_sel #(.LANES(LANES), .RES_W(RES_W)) u_sel (
    .ptr(ptr), .done(lane_done), .res_bus(lane_res), .ovr(lane_ovr),
    .sel_res(sel_res), .sel_done(sel_done), .sel_ovr(sel_ovr)
  );

  assign take = pend_sel & sel_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_out <= '0;
      smp_vld <= 1'b0;
      smp_ovr <= 1'b0;
    end else begin
      smp_vld <= take;
      smp_ovr <= take & sel_ovr;
      smp_out <= take ? {sel_res, {PAD_W{1'b0}}} : '0;
    end
  end

  // R3: a pending slot with its lane done yields a valid word next cycle
  a_r3_due_valid: assert property (@(posedge clk) disable iff (rst)
    (pend_sel && sel_done) |=> smp_vld);
  // R4: an unsampled slot gives no output
  a_r4_idle_slot: assert property (@(posedge clk) disable iff (rst)
    !pend_sel |=> (!smp_vld && smp_out == '0));
  // R5: low pad bits stay zero
  a_r5_low_pad: assert property (@(posedge clk) disable iff (rst)
    smp_out[PAD_W-1:0] == '0);
  // R6: overrange never appears without a valid word
  a_r6_ovr_with_vld: assert property (@(posedge clk) disable iff (rst)
    smp_ovr |-> smp_vld);
  // R7: a lane not done blocks the word
  a_r7_not_done: assert property (@(posedge clk) disable iff (rst)
    !sel_done |=> !smp_vld);
endmodule

// File: tb/lane_combiner_tb.sv
module lane_combiner_tb;
  localparam int LANES = 16;
  localparam int RES_W = 10;
  localparam int OUT_W = 16;
  localparam int NCYC  = 320;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   smp_stb = 1'b0;
  logic [LANES-1:0]       lane_done = '0;
  logic [LANES*RES_W-1:0] lane_res = '0;
  logic [LANES-1:0]       lane_ovr = '0;
  logic [OUT_W-1:0]       smp_out;
  logic                   smp_vld;
  logic                   smp_ovr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic             stb_hist [NCYC];
  logic             e_vld, e_ovr;
  logic [OUT_W-1:0] e_out;
  string            e_tag;
  int               vld_run = 0;

  always #5 clk = ~clk;

  lane_combiner #(.LANES(LANES), .RES_W(RES_W), .OUT_W(OUT_W)) u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .lane_done(lane_done),
    .lane_res(lane_res), .lane_ovr(lane_ovr),
    .smp_out(smp_out), .smp_vld(smp_vld), .smp_ovr(smp_ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [RES_W-1:0] res_of(input int n, input int k);
    if (n % 16 == 5) return 10'h3FF;
    if (n % 16 == 6) return 10'h000;
    return RES_W'((k << 6) ^ (n * 13));
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", 32'(smp_vld), 0);
    chk("R1 ovr in reset", 32'(smp_ovr), 0);
    chk("R1 out in reset", 32'(smp_out), 0);
    e_vld = 1'b0; e_ovr = 1'b0; e_out = '0; e_tag = "R1";
    for (int n = 0; n < NCYC; n++) begin
      logic stb;
      logic [LANES-1:0] dn;
      logic [LANES-1:0] ov;
      int lane;
      if (n > 0) begin
        chk({e_tag, " valid"}, 32'(smp_vld), 32'(e_vld));
        chk("R2 R5 data", 32'(smp_out), 32'(e_out));
        chk("R6 ovr", 32'(smp_ovr), 32'(e_ovr));
        if (n >= 17 && n <= 64) vld_run += int'(smp_vld);
        if (n == 64) chk("R9 full rate count", 32'(vld_run), 48);
      end
      // stimulus for edge n
      if (n < 64)       stb = 1'b1;
      else if (n < 160) stb = (n % 3 != 0);
      else if (n < 256) stb = 1'b1;
      else              stb = (n % 5 == 1);
      dn = '1;
      for (int k = 0; k < LANES; k++) begin
        if (n >= 160 && n < 256 && ((k + n) % 5 == 0)) dn[k] = 1'b0;
        ov[k] = ((n + k) % 7 == 0);
        lane_res[k*RES_W +: RES_W] = res_of(n, k);
      end
      stb_hist[n] = stb;
      rst = 1'b0;
      smp_stb = stb;
      lane_done = dn;
      lane_ovr = ov;
      lane = n % LANES;
      // expectation visible after edge n
      if (n < 16) begin
        e_vld = 1'b0; e_tag = "R8";
      end else if (!stb_hist[n-16]) begin
        e_vld = 1'b0; e_tag = "R4";
      end else if (!dn[lane]) begin
        e_vld = 1'b0; e_tag = "R7";
      end else begin
        e_vld = 1'b1; e_tag = "R3";
      end
      e_ovr = e_vld & ov[lane];
      e_out = e_vld ? {res_of(n, lane), 6'b0} : '0;
      @(negedge clk);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule